// File: doc/BRIEF.md
# Wrapping Hardware Stack Pointer

This block keeps the stack pointer of an 8-bit processor and generates every stack memory access the processor makes. The stack is a fixed window of 128 bytes at addresses 0100h to 017Fh. Only the low seven bits of the 16-bit pointer change; the upper bits are tied so that the pointer stays inside the window. The pointer always names the next free byte. A push writes at the pointer and then moves it down. A pop first moves the pointer up and then reads. Movement past either end of the window wraps to the other end, and nothing reports the wrap.

Besides single-byte push and pop, the block runs two multi-byte frame sequences and moves one byte per clock. A subroutine call stores the program counter in two bytes, and its return brings them back. An interrupt entry stores a five-byte context, and interrupt exit restores it in reverse order. While a frame runs, `busy` is high and every other command is ignored. The memory array sits outside the block. Reads from it are combinational and writes take effect on the clock edge.

Top module: `stack_ptr_unit`

## Requirements
- R1: Every stack access presents an address whose bits 15:7 equal those of 0100h, so every access falls in 0100h..017Fh.
- R2: After reset, and one cycle after an accepted `rsp_cmd`, `sp_out` is 017Fh.
- R3: An accepted push writes `push_data` at `sp_out` and decrements the pointer. An accepted pop increments the pointer, reads at the new value, and shows that byte on `pop_data` after the same edge.
- R4: A decrement from 0100h gives 017Fh, and an increment from 017Fh gives 0100h. This applies to single bytes and inside frames.
- R5: `call_req` stores the low byte of `pc_in` at the pointer and the high byte one below it, leaving the pointer 2 lower. `ret_req` reads the two bytes back onto `pc_out` and leaves the pointer 2 higher.
- R6: `irq_save` stores 5 bytes at descending addresses in the order PC low, PC high, X, A, CC, using the input values sampled on the trigger edge. The pointer ends 5 lower. No other register is saved.
- R7: `irq_restore` reads 5 bytes at ascending addresses in the order CC, A, X, PC high, PC low onto the restore outputs. The pointer ends 5 higher.
- R8: An accepted `sp_load` replaces bits 6:0 of the pointer with bits 6:0 of `sp_load_val`. Bit 7 of `sp_load_val` has no effect.
- R9: After a frame trigger, `busy` is high for exactly as many cycles as the frame has bytes (2 or 5). While `busy` is high, push, pop, load, reset-stack and trigger inputs have no effect.
- R10: At most one byte moves per cycle: `mem_we` and `mem_re` are never high together. When idle, the command priority is rsp_cmd, sp_load, irq_save, irq_restore, call_req, ret_req, push_req, pop_req.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| push_req | input | 1 | Push one byte |
| push_data | input | 8 | Byte to push |
| pop_req | input | 1 | Pop one byte |
| call_req | input | 1 | Start the 2-byte call frame save |
| ret_req | input | 1 | Start the 2-byte return frame restore |
| irq_save | input | 1 | Start the 5-byte interrupt context save |
| irq_restore | input | 1 | Start the 5-byte interrupt context restore |
| rsp_cmd | input | 1 | Reset the pointer to the window top |
| sp_load | input | 1 | Load the pointer low byte |
| sp_load_val | input | 8 | Value for the low-byte load |
| pc_in | input | 16 | Program counter to save |
| x_in | input | 8 | X register to save |
| a_in | input | 8 | Accumulator to save |
| cc_in | input | 8 | Condition code to save |
| mem_rdata | input | 8 | Combinational read data from stack memory |
| mem_addr | output | 16 | Stack memory address |
| mem_wdata | output | 8 | Stack memory write data |
| mem_we | output | 1 | Write strobe |
| mem_re | output | 1 | Read strobe |
| pop_data | output | 8 | Last popped byte |
| pc_out | output | 16 | Restored program counter |
| x_out | output | 8 | Restored X |
| a_out | output | 8 | Restored accumulator |
| cc_out | output | 8 | Restored condition code |
| sp_out | output | 16 | Current stack pointer |
| busy | output | 1 | Frame sequence running |

## Verification
The hardest case to reach is a five-byte frame that crosses the window boundary partway through, because the wrap must happen between two bytes of the same sequence. The stimulus reaches it by loading the pointer low byte with 02h before the interrupt save. The save then writes across 0100h into the top of the window, and the restore must wrap back. A sweep of 130 pushes and the matching pops crosses both ends with single bytes. Frames run with every competing command held high, to show they are ignored.

// File: rtl/stkp_pkg.sv
package stkp_pkg;
   typedef enum logic [1:0] {FS_IDLE, FS_SAVE, FS_REST} fs_state_t;
   localparam int FRAME_CALL  = 2;
   localparam int FRAME_IRQ   = 5;
   localparam int FRAME_IDX_W = 3;
endpackage

// File: rtl/stkp_pointer.sv
module stkp_pointer #(
   parameter int ADDR_W = 16,
   parameter int OFFS_W = 7,
   parameter logic [ADDR_W-1:0] BASE = 16'h0100
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_top,
   input  logic              load_low,
   input  logic [OFFS_W-1:0] low_val,
   input  logic              dec,
   input  logic              inc,
   output logic [ADDR_W-1:0] sp_cur,
   output logic [ADDR_W-1:0] sp_above
);
   localparam int HI_W = ADDR_W - OFFS_W;
   localparam logic [HI_W-1:0] HI_BITS = BASE[ADDR_W-1:OFFS_W];

   generate
      if (OFFS_W < 1 || OFFS_W >= ADDR_W) begin : g_bad_offs
         $error("stkp_pointer: OFFS_W out of range");
      end
      if (BASE[OFFS_W-1:0] != '0) begin : g_bad_base
         $error("stkp_pointer: BASE not aligned to window");
      end
   endgenerate

   logic [OFFS_W-1:0] offs_q;
   logic [OFFS_W-1:0] offs_up;
   logic [OFFS_W-1:0] offs_dn;

   assign offs_up  = offs_q + 1'b1;
   assign offs_dn  = offs_q - 1'b1;
   assign sp_cur   = {HI_BITS, offs_q};
   assign sp_above = {HI_BITS, offs_up};

   always_ff @(posedge clk) begin
      if (!rst_n)        offs_q <= '1;
      else if (load_top) offs_q <= '1;
      else if (load_low) offs_q <= low_val;
      else if (dec)      offs_q <= offs_dn;
      else if (inc)      offs_q <= offs_up;
   end

   p_cmd_onehot_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({load_top, load_low, dec, inc}));
   p_wrap_down_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (dec && !load_top && !load_low && offs_q == '0) |=> (offs_q == '1));
   p_wrap_up_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (inc && !load_top && !load_low && offs_q == '1) |=> (offs_q == '0));
endmodule

// File: rtl/stkp_frame_seq.sv
module stkp_frame_seq
   import stkp_pkg::*;
(
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   start_save,
   input  logic                   start_rest,
   input  logic                   long_frame,
   output logic                   busy,
   output logic                   saving,
   output logic                   restoring,
   output logic [FRAME_IDX_W-1:0] idx
);
   localparam logic [FRAME_IDX_W-1:0] LAST_LONG  = FRAME_IDX_W'(FRAME_IRQ - 1);
   localparam logic [FRAME_IDX_W-1:0] LAST_SHORT = FRAME_IDX_W'(FRAME_CALL - 1);

   fs_state_t              state_q;
   logic [FRAME_IDX_W-1:0] last_q;
   logic [FRAME_IDX_W-1:0] start_last;

   assign start_last = long_frame ? LAST_LONG : LAST_SHORT;
   assign saving     = (state_q == FS_SAVE);
   assign restoring  = (state_q == FS_REST);
   assign busy       = (state_q != FS_IDLE);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= FS_IDLE;
         idx     <= '0;
         last_q  <= '0;
      end else begin
         case (state_q)
            FS_IDLE: begin
               if (start_save) begin
                  state_q <= FS_SAVE;
                  idx     <= '0;
                  last_q  <= start_last;
               end else if (start_rest) begin
                  state_q <= FS_REST;
                  idx     <= start_last;
               end
            end
            FS_SAVE: begin
               if (idx == last_q) state_q <= FS_IDLE;
               else               idx <= idx + 1'b1;
            end
            FS_REST: begin
               if (idx == '0) state_q <= FS_IDLE;
               else           idx <= idx - 1'b1;
            end
            default: state_q <= FS_IDLE;
         endcase
      end
   end

   // Run-length checker for the busy window
   logic [FRAME_IDX_W:0] run_cnt;
   logic [FRAME_IDX_W:0] run_len;
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         run_cnt <= '0;
         run_len <= '0;
      end else if (!busy && (start_save || start_rest)) begin
         run_cnt <= '0;
         run_len <= {1'b0, start_last} + 1'b1;
      end else if (busy) begin
         run_cnt <= run_cnt + 1'b1;
      end
   end

   p_busy_len_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> (run_cnt == run_len));
   p_save_first_pcl_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && start_save) |=> (saving && idx == '0));
   p_rest_first_cc_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !start_save && start_rest && long_frame) |=> (restoring && idx == LAST_LONG));
endmodule

// File: rtl/stack_ptr_unit.sv
module stack_ptr_unit
   import stkp_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int ADDR_W = 16,
   parameter int OFFS_W = 7,
   parameter logic [ADDR_W-1:0] BASE = 16'h0100
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                push_req,
   input  logic [DATA_W-1:0]   push_data,
   input  logic                pop_req,
   input  logic                call_req,
   input  logic                ret_req,
   input  logic                irq_save,
   input  logic                irq_restore,
   input  logic                rsp_cmd,
   input  logic                sp_load,
   input  logic [DATA_W-1:0]   sp_load_val,
   input  logic [2*DATA_W-1:0] pc_in,
   input  logic [DATA_W-1:0]   x_in,
   input  logic [DATA_W-1:0]   a_in,
   input  logic [DATA_W-1:0]   cc_in,
   input  logic [DATA_W-1:0]   mem_rdata,
   output logic [ADDR_W-1:0]   mem_addr,
   output logic [DATA_W-1:0]   mem_wdata,
   output logic                mem_we,
   output logic                mem_re,
   output logic [DATA_W-1:0]   pop_data,
   output logic [2*DATA_W-1:0] pc_out,
   output logic [DATA_W-1:0]   x_out,
   output logic [DATA_W-1:0]   a_out,
   output logic [DATA_W-1:0]   cc_out,
   output logic [ADDR_W-1:0]   sp_out,
   output logic                busy
);
   localparam logic [ADDR_W-1:0] TOP_ADDR = BASE | ADDR_W'((1 << OFFS_W) - 1);

   generate
      if (DATA_W <= OFFS_W) begin : g_bad_data
         $error("stack_ptr_unit: DATA_W must exceed OFFS_W");
      end
   endgenerate

   logic                   saving, restoring;
   logic [FRAME_IDX_W-1:0] idx;
   logic [ADDR_W-1:0]      sp_cur, sp_above;
   logic acc_rsp, acc_ld, acc_isv, acc_irs, acc_call, acc_ret, acc_push, acc_pop;
   logic start_save, start_rest, long_frame;
   logic sig_unused;
   logic [DATA_W-1:0] snap_q [FRAME_IRQ];
   logic [DATA_W-1:0] rest_q [FRAME_IRQ];

   assign sig_unused = ^sp_load_val[DATA_W-1:OFFS_W];

   always_comb begin
      {acc_rsp, acc_ld, acc_isv, acc_irs, acc_call, acc_ret, acc_push, acc_pop} = '0;
      if (!busy) begin
         if (rsp_cmd)          acc_rsp  = 1'b1;
         else if (sp_load)     acc_ld   = 1'b1;
         else if (irq_save)    acc_isv  = 1'b1;
         else if (irq_restore) acc_irs  = 1'b1;
         else if (call_req)    acc_call = 1'b1;
         else if (ret_req)     acc_ret  = 1'b1;
         else if (push_req)    acc_push = 1'b1;
         else if (pop_req)     acc_pop  = 1'b1;
      end
   end

   assign start_save = acc_isv | acc_call;
   assign start_rest = acc_irs | acc_ret;
   assign long_frame = acc_isv | acc_irs;

   stkp_frame_seq u_seq (
      .clk(clk), .rst_n(rst_n), .start_save(start_save), .start_rest(start_rest),
      .long_frame(long_frame), .busy(busy), .saving(saving), .restoring(restoring),
      .idx(idx)
   );

   always_comb begin
      mem_addr  = sp_cur;
      mem_wdata = push_data;
      mem_we    = 1'b0;
      mem_re    = 1'b0;
      if (saving) begin
         mem_we    = 1'b1;
         mem_wdata = snap_q[idx];
      end else if (restoring) begin
         mem_re   = 1'b1;
         mem_addr = sp_above;
      end else if (acc_push) begin
         mem_we = 1'b1;
      end else if (acc_pop) begin
         mem_re   = 1'b1;
         mem_addr = sp_above;
      end
   end

   stkp_pointer #(.ADDR_W(ADDR_W), .OFFS_W(OFFS_W), .BASE(BASE)) u_ptr (
      .clk(clk), .rst_n(rst_n), .load_top(acc_rsp), .load_low(acc_ld),
      .low_val(sp_load_val[OFFS_W-1:0]), .dec(mem_we), .inc(mem_re),
      .sp_cur(sp_cur), .sp_above(sp_above)
   );

   assign sp_out = sp_cur;

   // Snapshot of the frame, slot order is the save order
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < FRAME_IRQ; i++) snap_q[i] <= '0;
      end else if (start_save) begin
         snap_q[0] <= pc_in[DATA_W-1:0];
         snap_q[1] <= pc_in[2*DATA_W-1:DATA_W];
         snap_q[2] <= x_in;
         snap_q[3] <= a_in;
         snap_q[4] <= cc_in;
      end
   end

   genvar g;
   generate
      for (g = 0; g < FRAME_IRQ; g++) begin : g_rest
         always_ff @(posedge clk) begin
            if (!rst_n)                                  rest_q[g] <= '0;
            else if (restoring && idx == FRAME_IDX_W'(g)) rest_q[g] <= mem_rdata;
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)       pop_data <= '0;
      else if (acc_pop) pop_data <= mem_rdata;
   end

   assign pc_out = {rest_q[1], rest_q[0]};
   assign x_out  = rest_q[2];
   assign a_out  = rest_q[3];
   assign cc_out = rest_q[4];

   p_window_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_we || mem_re) |-> (mem_addr[ADDR_W-1:OFFS_W] == BASE[ADDR_W-1:OFFS_W]));
   p_rsp_top_r2: assert property (@(posedge clk) disable iff (!rst_n)
      acc_rsp |=> (sp_out == TOP_ADDR));
   p_push_at_sp_r3: assert property (@(posedge clk) disable iff (!rst_n)
      acc_push |-> (mem_we && mem_addr == sp_out && mem_wdata == push_data));
   p_load_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
      acc_ld |=> (sp_out[OFFS_W-1:0] == $past(sp_load_val[OFFS_W-1:0])));
   p_one_strobe_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_we && mem_re));
   p_busy_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !$past(busy)) |-> (mem_we || mem_re));
endmodule

// File: tb/stack_ptr_unit_bench.sv
module stack_ptr_unit_bench;
   localparam int CLK_PERIOD = 10;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic push_req = 0, pop_req = 0, call_req = 0, ret_req = 0;
   logic irq_save = 0, irq_restore = 0, rsp_cmd = 0, sp_load = 0;
   logic [7:0] push_data = 0, sp_load_val = 0, x_in = 0, a_in = 0, cc_in = 0;
   logic [15:0] pc_in = 0;
   logic [7:0] mem_rdata;
   logic [15:0] mem_addr, sp_out, pc_out;
   logic [7:0] mem_wdata, pop_data, x_out, a_out, cc_out;
   logic mem_we, mem_re, busy;

   int n_chk = 0, n_fail = 0, win_err = 0, both_err = 0;
   int exp_sp;
   logic [7:0] bmem [128];
   logic [7:0] exp_mem [128];
   logic done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   stack_ptr_unit u_stack_ptr_unit (
      .clk(clk), .rst_n(rst_n), .push_req(push_req), .push_data(push_data),
      .pop_req(pop_req), .call_req(call_req), .ret_req(ret_req), .irq_save(irq_save),
      .irq_restore(irq_restore), .rsp_cmd(rsp_cmd), .sp_load(sp_load),
      .sp_load_val(sp_load_val), .pc_in(pc_in), .x_in(x_in), .a_in(a_in), .cc_in(cc_in),
      .mem_rdata(mem_rdata), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we),
      .mem_re(mem_re), .pop_data(pop_data), .pc_out(pc_out), .x_out(x_out), .a_out(a_out),
      .cc_out(cc_out), .sp_out(sp_out), .busy(busy)
   );

   assign mem_rdata = bmem[mem_addr[6:0]];
   always @(posedge clk) begin
      if (mem_we) bmem[mem_addr[6:0]] <= mem_wdata;
      if (rst_n && (mem_we || mem_re) && mem_addr[15:7] != 9'h002) win_err++;
      if (rst_n && mem_we && mem_re) both_err++;
   end

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic cyc();
      @(posedge clk);
      #1;
   endtask

   function automatic logic [15:0] spa(int o);
      return 16'h0100 | 16'(o & 127);
   endfunction

   task automatic do_push(logic [7:0] v);
      push_req = 1; push_data = v; cyc(); push_req = 0;
      exp_mem[exp_sp] = v; exp_sp = (exp_sp - 1) & 127;
      chk("R3/R4 push sp", sp_out, spa(exp_sp));
   endtask

   task automatic do_pop(bit chk_data);
      pop_req = 1; cyc(); pop_req = 0;
      exp_sp = (exp_sp + 1) & 127;
      chk("R3/R4 pop sp", sp_out, spa(exp_sp));
      if (chk_data) chk("R3 pop data", pop_data, exp_mem[exp_sp]);
   endtask

   // trigger is already set by caller; noise holds competing inputs during busy
   task automatic frame(int len, bit noise, string tag);
      cyc();
      {call_req, ret_req, irq_save, irq_restore} = '0;
      for (int k = 0; k < len; k++) begin
         chk({tag, " busy high"}, busy, 1);
         if (noise) begin push_req = 1; pop_req = 1; rsp_cmd = 1; sp_load = 1; irq_save = 1; end
         cyc();
      end
      chk({tag, " busy low"}, busy, 0);
      {push_req, pop_req, rsp_cmd, sp_load, irq_save} = '0;
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < 128; i++) begin bmem[i] = 0; exp_mem[i] = 0; end
      exp_sp = 127;
      repeat (3) cyc();
      rst_n = 1;
      chk("R2 reset sp", sp_out, 16'h017F);
      chk("R9 reset busy", busy, 0);
      chk("R10 reset strobes", {mem_we, mem_re}, 0);

      // R3 R4 sweep: 130 pushes wrap below 0100h, pops wrap above 017Fh
      for (int i = 0; i < 130; i++) do_push(8'(i * 37 + 5));
      for (int i = 0; i < 128; i++) do_pop(1);
      for (int i = 0; i < 3; i++) do_pop(0);
      chk("R4 wrap up reached 0100", sp_out, 16'h0100);

      // R2 reset-stack command
      do_push(8'h11);
      rsp_cmd = 1; cyc(); rsp_cmd = 0; exp_sp = 127;
      chk("R2 rsp sp", sp_out, 16'h017F);

      // R8 low-byte load, bit 7 ignored
      sp_load = 1; sp_load_val = 8'hA5; cyc(); sp_load = 0;
      chk("R8 load A5", sp_out, 16'h0125);
      sp_load = 1; sp_load_val = 8'h80; cyc(); sp_load = 0;
      chk("R8 load 80 drops bit7", sp_out, 16'h0100);

      // R10 priority: rsp beats load and push in the same cycle
      rsp_cmd = 1; sp_load = 1; push_req = 1; sp_load_val = 8'h10; cyc();
      {rsp_cmd, sp_load, push_req} = '0;
      chk("R10 rsp wins priority", sp_out, 16'h017F);

      // R5 call and return
      pc_in = 16'h1234; call_req = 1;
      frame(2, 0, "R5 call");
      chk("R5 call sp", sp_out, 16'h017D);
      chk("R5 PCL at top", bmem[127], 8'h34);
      chk("R5 PCH below", bmem[126], 8'h12);
      pc_in = 16'h0000; ret_req = 1;
      frame(2, 0, "R5 ret");
      chk("R5 ret pc", pc_out, 16'h1234);
      chk("R5 ret sp", sp_out, 16'h017F);

      // R6 R7 R4 interrupt frame crossing the window bottom
      sp_load = 1; sp_load_val = 8'h02; cyc(); sp_load = 0;
      pc_in = 16'hABCD; x_in = 8'h11; a_in = 8'h22; cc_in = 8'h33; irq_save = 1;
      frame(5, 0, "R6 save");
      chk("R6 save sp wraps", sp_out, 16'h017D);
      chk("R6 byte0 PCL", bmem[2], 8'hCD);
      chk("R6 byte1 PCH", bmem[1], 8'hAB);
      chk("R6 byte2 X", bmem[0], 8'h11);
      chk("R6 byte3 A", bmem[127], 8'h22);
      chk("R6 byte4 CC", bmem[126], 8'h33);
      pc_in = 0; x_in = 0; a_in = 0; cc_in = 0; irq_restore = 1;
      frame(5, 0, "R7 restore");
      chk("R7 pc", pc_out, 16'hABCD);
      chk("R7 x", x_out, 8'h11);
      chk("R7 a", a_out, 8'h22);
      chk("R7 cc", cc_out, 8'h33);
      chk("R7 sp", sp_out, 16'h0102);

      // R9 commands ignored during a frame
      pc_in = 16'h5A6B; x_in = 8'h7C; a_in = 8'h8D; cc_in = 8'h9E; irq_save = 1;
      frame(5, 1, "R9 noisy save");
      chk("R9 sp after noisy save", sp_out, 16'h017D);
      chk("R9 byte0 intact", bmem[2], 8'h6B);
      chk("R9 byte4 intact", bmem[126], 8'h9E);

      chk("R1 window on every access", win_err, 0);
      chk("R10 single strobe", both_err, 0);
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end
endmodule